// File: doc/BRIEF.md
# Windowed Register File Controller

This block gives a RISC integer core a circular stack of register windows. Each call level sees 32 architectural registers. Eight of them are globals shared by every level. Eight are locals owned by one window. The remaining sixteen form two overlapping groups: the caller's output group is the same storage as the callee's input group, so arguments pass between levels without any copy. The block turns each 5-bit architectural register number into an index into one flat physical array. It serves two combinational read ports and one clocked write port from that array.

A save request moves the window pointer up by one and a restore request moves it down by one, both modulo the window count. The block also keeps a savable count and a restorable count. A request that would run past the available windows does not move the pointer. Instead it produces a one-cycle trap request tagged as a spill (for a save) or a fill (for a restore), which the core's trap logic acts on. The other-window count, which the trap handlers use, is reported as a constant zero. This is because the block has no handler of its own that would move windows to or from memory.

Top module: `windowed_regfile`

## Requirements
- R1: Reset sets the window pointer to the parameter `RESET_CWP`, the savable count to NWIN-2, and the restorable count, the other-window count and `trapValid` to 0.
- R2: A save with a non-zero savable count takes effect at the next clock edge: the pointer becomes (pointer+1) mod NWIN, the savable count drops by 1 and the restorable count rises by 1.
- R3: A save with a savable count of 0 leaves the pointer and both counts unchanged. After the next edge it drives `trapValid`=1 with `trapKind`=2'b01 (spill).
- R4: A restore with a restorable count of 0, and no save in the same cycle, leaves the pointer and both counts unchanged. After the next edge it drives `trapValid`=1 with `trapKind`=2'b10 (fill).
- R5: A restore with a non-zero restorable count, and no save in the same cycle, sets the pointer to (pointer-1) mod NWIN, raises the savable count by 1 and lowers the restorable count by 1.
- R6: The savable, restorable and other-window counts always add up to NWIN-2.
- R7: Architectural registers 0–7 are globals, 8–15 outs, 16–23 locals and 24–31 ins. The outs of window W are the same storage as the ins of window (W+1) mod NWIN. Each window's locals are private to it.
- R8: Register 0 reads as zero on both ports, and a write to it has no effect.
- R9: When a save and a restore arrive in the same cycle, the save is acted on and the restore is ignored.
- R10: Both read ports decode independently and combinationally from the current pointer. A write is visible on either port from the cycle after its clock edge.
- R11: `trapValid` is high only in the cycle that follows a spill or fill request, and `trapKind` is 2'b00 whenever `trapValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| saveReq | input | 1 | Request to advance to a new window |
| restoreReq | input | 1 | Request to return to the previous window |
| rdAddrA | input | 5 | Architectural register number, read port A |
| rdAddrB | input | 5 | Architectural register number, read port B |
| rdDataA | output | XLEN | Read data, port A |
| rdDataB | output | XLEN | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural register number to write |
| wrData | input | XLEN | Write data |
| cwp | output | log2(NWIN) | Current window pointer |
| canSave | output | log2(NWIN) | Windows that can still be saved |
| canRestore | output | log2(NWIN) | Windows that can still be restored |
| otherWin | output | log2(NWIN) | Other-window count (held at 0) |
| trapValid | output | 1 | One-cycle trap request |
| trapKind | output | 2 | 01 spill, 10 fill, 00 none |

## Verification
Read data is combinational, so the bench sets the read addresses between clock edges and samples 1 ns later in the same cycle. The pointer, the counts and the trap outputs each pass through exactly one register. The bench therefore applies a save or restore at a falling edge and checks them 2 ns after the following rising edge. A write is applied the same way, and its value is checked on the first read made after that rising edge. The sweep starts near the top of the pointer range and runs the pointer through its wrap in both directions. After every window move it re-reads all 32 registers, so that the overlap across the wrap is covered.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned ARCH_REGS = 32;
  localparam int unsigned AW        = 5;
  localparam int unsigned NUM_GLOB  = 8;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'b00,
    TRAP_SPILL = 2'b01,
    TRAP_FILL  = 2'b10
  } trapKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;
    logic retreat;
    logic spill;
    logic fill;
  } winStrobe_t;
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned PW  = $clog2(wrf_pkg::NUM_GLOB + 16 * NWIN)
) (
  input  logic [CW-1:0]             curWin,
  input  logic [wrf_pkg::AW-1:0]    archReg,
  output logic [PW-1:0]             physReg
);
  logic [CW-1:0] nextWin;
  logic [CW-1:0] ownerWin;
  logic          upperHalf;

  always_comb begin
    nextWin   = curWin + 1'b1;   // NWIN is a power of two: wraps by width
    ownerWin  = curWin;
    upperHalf = 1'b0;
    unique case (archReg[4:3])
      2'd1: begin ownerWin = nextWin; upperHalf = 1'b1; end // outs = ins of next window
      2'd2: begin ownerWin = curWin;  upperHalf = 1'b0; end // locals
      2'd3: begin ownerWin = curWin;  upperHalf = 1'b1; end // ins
      default: ;
    endcase
    if (archReg[4:3] == 2'd0)
      physReg = PW'(archReg[2:0]);
    else
      physReg = PW'(wrf_pkg::NUM_GLOB) + PW'({ownerWin, upperHalf, archReg[2:0]});
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int unsigned NWIN = 8,
  localparam int unsigned CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 saveReq,
  input  logic                 restoreReq,
  output wrf_pkg::winStrobe_t  strobe,
  output logic [CW-1:0]        canSave,
  output logic [CW-1:0]        canRestore,
  output logic [CW-1:0]        otherWin,
  output logic                 trapValid,
  output wrf_pkg::trapKind_e   trapKind
);
  import wrf_pkg::*;

  localparam logic [CW-1:0] FREE_INIT = CW'(NWIN - 2);

  logic saveOk, restoreOk;

  assign saveOk    = (canSave != '0);
  assign restoreOk = (canRestore != '0);
  assign otherWin  = '0;

  always_comb begin
    strobe         = '0;
    strobe.advance = saveReq && saveOk;
    strobe.spill   = saveReq && !saveOk;
    strobe.retreat = !saveReq && restoreReq && restoreOk;
    strobe.fill    = !saveReq && restoreReq && !restoreOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      canSave    <= FREE_INIT;
      canRestore <= '0;
      trapValid  <= 1'b0;
      trapKind   <= TRAP_NONE;
    end else begin
      if (strobe.advance) begin
        canSave    <= canSave - 1'b1;
        canRestore <= canRestore + 1'b1;
      end else if (strobe.retreat) begin
        canSave    <= canSave + 1'b1;
        canRestore <= canRestore - 1'b1;
      end
      trapValid <= strobe.spill || strobe.fill;
      trapKind  <= strobe.spill ? TRAP_SPILL : (strobe.fill ? TRAP_FILL : TRAP_NONE);
    end
  end

  a_r6_count_sum: assert property (@(posedge clk) disable iff (!rstN)
    (32'(canSave) + 32'(canRestore) + 32'(otherWin)) == NWIN - 2);

  a_r3_spill_holds: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && canSave == '0) |=>
      (trapValid && trapKind == TRAP_SPILL && $stable(canSave) && $stable(canRestore)));

  a_r4_fill_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!saveReq && restoreReq && canRestore == '0) |=>
      (trapValid && trapKind == TRAP_FILL && $stable(canSave) && $stable(canRestore)));

  a_r9_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.advance, strobe.retreat, strobe.spill, strobe.fill}));

  a_r11_quiet_kind: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |-> trapKind == TRAP_NONE);
endmodule

// File: rtl/wrf_dpath.sv
module wrf_dpath #(
  parameter int unsigned NWIN      = 8,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned RESET_CWP = 0,
  localparam int unsigned CW       = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned PHYS     = wrf_pkg::NUM_GLOB + 16 * NWIN,
  localparam int unsigned PW       = $clog2(PHYS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wrf_pkg::winStrobe_t        strobe,
  input  logic [wrf_pkg::AW-1:0]     rdAddrA,
  input  logic [wrf_pkg::AW-1:0]     rdAddrB,
  output logic [XLEN-1:0]            rdDataA,
  output logic [XLEN-1:0]            rdDataB,
  input  logic                       wrEn,
  input  logic [wrf_pkg::AW-1:0]     wrAddr,
  input  logic [XLEN-1:0]            wrData,
  output logic [CW-1:0]              cwp
);
  import wrf_pkg::*;

  localparam int unsigned NPORT = 3;  // A, B, write

  logic [XLEN-1:0] regs [PHYS];
  logic [AW-1:0]   archAddr [NPORT];
  logic [PW-1:0]   physAddr [NPORT];

  assign archAddr[0] = rdAddrA;
  assign archAddr[1] = rdAddrB;
  assign archAddr[2] = wrAddr;

  for (genvar p = 0; p < NPORT; p++) begin : g_xlate
    wrf_xlate #(.NWIN(NWIN)) u_xlate (
      .curWin (cwp),
      .archReg(archAddr[p]),
      .physReg(physAddr[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp <= CW'(RESET_CWP);
    end else if (strobe.advance) begin
      cwp <= cwp + 1'b1;
    end else if (strobe.retreat) begin
      cwp <= cwp - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[physAddr[2]] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[physAddr[0]];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[physAddr[1]];

  a_r2_advance_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> cwp == CW'($past(cwp) + 1'b1));

  a_r5_retreat_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retreat |=> cwp == CW'($past(cwp) - 1'b1));

  a_r3_trap_freezes_cwp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.spill || strobe.fill) |=> $stable(cwp));

  a_r8_zero_slot: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile #(
  parameter int unsigned NWIN      = 8,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned RESET_CWP = 0,
  localparam int unsigned CW       = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            saveReq,
  input  logic            restoreReq,
  input  logic [4:0]      rdAddrA,
  input  logic [4:0]      rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [4:0]      wrAddr,
  input  logic [XLEN-1:0] wrData,
  output logic [CW-1:0]   cwp,
  output logic [CW-1:0]   canSave,
  output logic [CW-1:0]   canRestore,
  output logic [CW-1:0]   otherWin,
  output logic            trapValid,
  output logic [1:0]      trapKind
);
  import wrf_pkg::*;

  winStrobe_t strobe;
  trapKind_e  trapKindE;

  wrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .saveReq   (saveReq),
    .restoreReq(restoreReq),
    .strobe    (strobe),
    .canSave   (canSave),
    .canRestore(canRestore),
    .otherWin  (otherWin),
    .trapValid (trapValid),
    .trapKind  (trapKindE)
  );

  wrf_dpath #(.NWIN(NWIN), .XLEN(XLEN), .RESET_CWP(RESET_CWP)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cwp    (cwp)
  );

  assign trapKind = trapKindE;
endmodule

// File: tb/sim_windowed_regfile.sv
`timescale 1ns/1ps
module sim_windowed_regfile;
  localparam int N   = 8;
  localparam int RC  = 5;
  localparam int XL  = 32;

  logic clk = 0, rstN = 0;
  logic saveReq = 0, restoreReq = 0, wrEn = 0;
  logic [4:0] rdAddrA = 0, rdAddrB = 0, wrAddr = 0;
  logic [XL-1:0] wrData = 0, rdDataA, rdDataB;
  logic [2:0] cwp, canSave, canRestore, otherWin;
  logic trapValid;
  logic [1:0] trapKind;

  always #10 clk = ~clk;  // 50 MHz

  windowed_regfile #(.NWIN(N), .XLEN(XL), .RESET_CWP(RC)) u0 (.*);

  int checks = 0, errors = 0;
  int mCwp, mCs, mCr, stamp = 0;
  logic [XL-1:0] mGlob [8];
  logic [XL-1:0] mLoc  [N][8];
  logic [XL-1:0] mIns  [N][8];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] expReg(int r);
    if (r == 0) return '0;
    if (r < 8)  return mGlob[r];
    if (r < 16) return mIns[(mCwp + 1) % N][r - 8];
    if (r < 24) return mLoc[mCwp][r - 16];
    return mIns[mCwp][r - 24];
  endfunction

  task automatic modelWrite(int r, logic [XL-1:0] v);
    if (r == 0) return;
    if (r < 8)       mGlob[r] = v;
    else if (r < 16) mIns[(mCwp + 1) % N][r - 8] = v;
    else if (r < 24) mLoc[mCwp][r - 16] = v;
    else             mIns[mCwp][r - 24] = v;
  endtask

  task automatic writeReg(int r, logic [XL-1:0] v);
    @(negedge clk);
    wrEn = 1; wrAddr = 5'(r); wrData = v;
    @(posedge clk);
    #1 wrEn = 0;
    modelWrite(r, v);
  endtask

  // R7/R10/R8: every register on both ports, B in reverse order
  task automatic verifyAll(string tag);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      rdAddrA = 5'(r); rdAddrB = 5'(31 - r);
      #1;
      chk({tag, " R7 R10 portA"}, rdDataA, expReg(r));
      chk({tag, " R7 R10 portB"}, rdDataB, expReg(31 - r));
    end
  endtask

  task automatic checkState(string req, logic tv, logic [1:0] tk);
    chk({req, " cwp"}, 32'(cwp), 32'(mCwp));
    chk({req, " canSave"}, 32'(canSave), 32'(mCs));
    chk({req, " canRestore"}, 32'(canRestore), 32'(mCr));
    chk("R6 sum", 32'(canSave) + 32'(canRestore) + 32'(otherWin), N - 2);
    chk({req, " trapValid"}, 32'(tv ? 1 : 0), 32'(trapValid));
    chk({req, " trapKind"}, 32'(trapKind), 32'(tk));
  endtask

  // apply request for one cycle, sample 2 ns after the edge
  task automatic request(logic s, logic r);
    @(negedge clk);
    saveReq = s; restoreReq = r;
    @(posedge clk);
    #2;
    saveReq = 0; restoreReq = 0;
  endtask

  task automatic refreshWindow();
    for (int r = 8; r < 24; r++) begin
      stamp++;
      writeReg(r, {8'(mCwp), 8'(r), 16'(stamp * 37)});
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mGlob[i] = '0;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 8; i++) begin mLoc[w][i] = '0; mIns[w][i] = '0; end
    mCwp = RC; mCs = N - 2; mCr = 0;

    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    checkState("R1 reset", 1'b0, 2'b00);
    chk("R1 otherWin", 32'(otherWin), 0);

    // R4: restore with nothing restorable
    request(0, 1);
    checkState("R4 fill", 1'b1, 2'b10);
    request(0, 0);
    checkState("R11 idle after trap", 1'b0, 2'b00);

    // R8: write to register 0 discarded; fill whole window
    for (int r = 0; r < 32; r++) writeReg(r, {8'hC0, 8'(r), 16'h5A00 + 16'(r)});
    verifyAll("base");

    // R2: saves across the wrap, with overlap checks
    for (int k = 0; k < N - 2; k++) begin
      request(1, 0);
      mCwp = (mCwp + 1) % N; mCs--; mCr++;
      checkState("R2 save", 1'b0, 2'b00);
      verifyAll("after save");
      refreshWindow();
      verifyAll("refresh");
    end

    // R3: no savable window
    request(1, 0);
    checkState("R3 spill", 1'b1, 2'b01);
    // R9: both at once while full -> spill, restore ignored
    request(1, 1);
    checkState("R9 both full", 1'b1, 2'b01);
    request(0, 0);
    checkState("R11 clears", 1'b0, 2'b00);

    // R5: restores back down across the wrap
    for (int k = 0; k < N - 2; k++) begin
      request(0, 1);
      mCwp = (mCwp + N - 1) % N; mCs++; mCr--;
      checkState("R5 restore", 1'b0, 2'b00);
      verifyAll("after restore");
    end
    request(0, 1);
    checkState("R4 fill again", 1'b1, 2'b10);

    // R9: both at once with room -> save wins
    request(1, 1);
    mCwp = (mCwp + 1) % N; mCs--; mCr++;
    checkState("R9 save priority", 1'b0, 2'b00);
    verifyAll("R9 window");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule